// File: doc/BRIEF.md
# Calendar time counter

This block keeps wall-clock time and date: seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-second strobe advances the time, with carries through every field, the true length of each month and a leap-year rule that follows the Gregorian calendar. The century used for that rule comes in on a port and is combined with the two-digit year.

The seven fields appear on output registers in one of two encodings, chosen by a mode input: packed BCD or plain binary. A second mode input selects 24-hour or 12-hour hours. In 12-hour form, bit 7 of the hour field marks the afternoon. Time is kept internally in binary. The visible registers are re-encoded on every clock edge, so a mode change shows on the next edge.

A host writes fields through a load port. The values are interpreted in the current encoding. Outside set mode a load takes effect at once. While set mode is held, the visible registers freeze and take raw host values, and the whole set is decoded and committed when set mode drops.

Top module: `caltime_core`

## Requirements
- R1: After reset the outputs show 00:00:00, day of week 1, day 1, month 1, year 00.
- R2: A tick sampled on a clock edge advances the time on that edge. Seconds wrap after 59 into minutes, minutes wrap after 59 into hours, and hours wrap after 23 into the next day.
- R3: The day of week counts 1 to 7 and steps from 7 back to 1 at midnight.
- R4: The day of month wraps to 1 after the last day of the month (31 for months 1,3,5,7,8,10,12; 30 for months 4,6,9,11; 28 or 29 for month 2). Month 12 wraps to 1 and advances the year, and year 99 wraps to 00.
- R5: February has 29 days when the two-digit year is a multiple of 4 and is either nonzero or paired with a century input that is a multiple of 4.
- R6: With `fmt_binary`=1 each field is output as its plain value. With `fmt_binary`=0 it is output as tens in bits 7:4 and units in bits 3:0.
- R7: With `fmt_24h`=0 the hour shows as 1..12 with hour 0 shown as 12 and bit 7 set for hours 12..23. A loaded 12-hour value has bit 7 removed, is taken modulo 12, and gains 12 when bit 7 was set.
- R8: Outside set mode a change of either mode input re-encodes all outputs on the next clock edge.
- R9: With `hold_set`=0, `ld_en` loads `ld_data`, decoded in the current modes, into the field picked by `ld_sel` (0 sec, 1 min, 2 hour, 3 day of week, 4 day of month, 5 month, 6 year). The result is visible after the next edge. `ld_sel`=7 changes nothing. A load in the same cycle as a tick wins, and that tick is dropped.
- R10: With `hold_set`=1 ticks and mode changes leave the outputs unchanged, and a load writes `ld_data` unaltered into the selected output. On the edge where `hold_set` is first seen low, the outputs are decoded in the modes of that cycle and become the time.
- R11: A loaded year is reduced modulo 100 after decoding.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_1s | input | 1 | One-cycle strobe, once per second |
| fmt_binary | input | 1 | 1 binary encoding, 0 BCD |
| fmt_24h | input | 1 | 1 24-hour hours, 0 12-hour with PM flag |
| hold_set | input | 1 | Set mode: freeze outputs, stage loads |
| century | input | CEN_W | Binary century for the leap-year rule |
| ld_en | input | 1 | Load strobe |
| ld_sel | input | 3 | Field select for the load |
| ld_data | input | 8 | Field value in the current encoding |
| sec_o | output | 8 | Seconds |
| min_o | output | 8 | Minutes |
| hour_o | output | 8 | Hours, bit 7 PM flag in 12-hour mode |
| wday_o | output | 8 | Day of week 1..7 |
| mday_o | output | 8 | Day of month |
| mon_o | output | 8 | Month 1..12 |
| year_o | output | 8 | Year 00..99 |

## Verification
An error in the carry chain shows on the outputs only when a boundary is crossed. The test therefore loads each rollover point directly (59 seconds, 23 hours, day 7, the last day of 30-day months, 31-day months and February in four leap cases, December, year 99) and compares the fields one edge after the tick. An internal value that is right but encoded wrongly shows on the edge after a mode change, so each mode flip is checked on that edge. A stale staged value in set mode stays hidden until commit; it is caught by committing under a mode different from the one the raw value was written in and then ticking once.

// File: rtl/caltime_pkg.sv
package caltime_pkg;

  localparam int FLD_W   = 8;
  localparam int NUM_FLD = 7;
  localparam int SEL_W   = 3;

  localparam int I_SEC  = 0;
  localparam int I_MIN  = 1;
  localparam int I_HOUR = 2;
  localparam int I_WDAY = 3;
  localparam int I_MDAY = 4;
  localparam int I_MON  = 5;
  localparam int I_YEAR = 6;

  typedef logic [FLD_W-1:0] fld_t;
  typedef fld_t [NUM_FLD-1:0] cal_t;

  // year, month, mday, wday, hour, min, sec (index 6 down to 0)
  localparam cal_t CAL_RESET = {8'd0, 8'd1, 8'd1, 8'd1, 8'd0, 8'd0, 8'd0};

  function automatic fld_t bin_to_bcd(input fld_t v);
    fld_t tens;
    fld_t ones;
    tens = v / 8'd10;
    ones = v % 8'd10;
    return (tens << 4) | ones;
  endfunction

  function automatic fld_t bcd_to_bin(input fld_t v);
    return ({4'd0, v[7:4]} * 8'd10) + {4'd0, v[3:0]};
  endfunction

  function automatic fld_t to_ext(input fld_t v, input logic bin_mode);
    return bin_mode ? v : bin_to_bcd(v);
  endfunction

  function automatic fld_t from_ext(input fld_t v, input logic bin_mode);
    return bin_mode ? v : bcd_to_bin(v);
  endfunction

  function automatic fld_t encode_field(input int idx, input fld_t v,
                                        input logic bin_mode, input logic h24);
    fld_t h12;
    if (idx == I_HOUR && !h24) begin
      h12 = v % 8'd12;
      if (h12 == 8'd0) h12 = 8'd12;
      return to_ext(h12, bin_mode) | ((v >= 8'd12) ? 8'h80 : 8'h00);
    end
    return to_ext(v, bin_mode);
  endfunction

  function automatic fld_t decode_field(input int idx, input fld_t raw,
                                        input logic bin_mode, input logic h24);
    fld_t v;
    if (idx == I_HOUR) begin
      v = from_ext(raw & 8'h7F, bin_mode);
      if (!h24) v = (v % 8'd12) + (raw[7] ? 8'd12 : 8'd0);
    end else begin
      v = from_ext(raw, bin_mode);
    end
    if (idx == I_YEAR) begin
      if (v >= 8'd200)      v = v - 8'd200;
      else if (v >= 8'd100) v = v - 8'd100;
    end
    return v;
  endfunction

  function automatic fld_t days_in_month(input fld_t mon, input logic leap);
    case (mon)
      8'd2:                    return leap ? 8'd29 : 8'd28;
      8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
      default:                 return 8'd31;
    endcase
  endfunction

endpackage

// File: rtl/caltime_step.sv
module caltime_step
  import caltime_pkg::*;
#(
  parameter int CEN_W = 7
) (
  input  cal_t             cur,
  input  logic [CEN_W-1:0] century,
  output cal_t             nxt
);

  logic leap;
  fld_t dim;
  logic c_min, c_hour, c_day, c_mon, c_year;

  always_comb begin
    leap = (cur[I_YEAR][1:0] == 2'b00) &&
           ((cur[I_YEAR] != 8'd0) || ((century & CEN_W'(3)) == '0));
    dim  = days_in_month(cur[I_MON], leap);

    c_min  = (cur[I_SEC]  >= 8'd59);
    c_hour = c_min  && (cur[I_MIN]  >= 8'd59);
    c_day  = c_hour && (cur[I_HOUR] >= 8'd23);
    c_mon  = c_day  && (cur[I_MDAY] >= dim);
    c_year = c_mon  && (cur[I_MON]  >= 8'd12);

    nxt = cur;
    nxt[I_SEC] = c_min ? 8'd0 : cur[I_SEC] + 8'd1;
    if (c_min)  nxt[I_MIN]  = c_hour ? 8'd0 : cur[I_MIN] + 8'd1;
    if (c_hour) nxt[I_HOUR] = c_day  ? 8'd0 : cur[I_HOUR] + 8'd1;
    if (c_day) begin
      nxt[I_WDAY] = (cur[I_WDAY] >= 8'd7) ? 8'd1 : cur[I_WDAY] + 8'd1;
      nxt[I_MDAY] = c_mon ? 8'd1 : cur[I_MDAY] + 8'd1;
    end
    if (c_mon)  nxt[I_MON]  = c_year ? 8'd1 : cur[I_MON] + 8'd1;
    if (c_year) nxt[I_YEAR] = (cur[I_YEAR] >= 8'd99) ? 8'd0 : cur[I_YEAR] + 8'd1;
  end

endmodule

// File: rtl/caltime_codec.sv
module caltime_codec
  import caltime_pkg::*;
(
  input  cal_t bin_in,
  input  cal_t ext_in,
  input  logic fmt_binary,
  input  logic fmt_24h,
  output cal_t ext_out,
  output cal_t bin_out
);

  for (genvar i = 0; i < NUM_FLD; i++) begin : g_fld
    assign ext_out[i] = encode_field(i, bin_in[i], fmt_binary, fmt_24h);
    assign bin_out[i] = decode_field(i, ext_in[i], fmt_binary, fmt_24h);
  end

endmodule

// File: rtl/caltime_core.sv
module caltime_core
  import caltime_pkg::*;
#(
  parameter int CEN_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1s,
  input  logic             fmt_binary,
  input  logic             fmt_24h,
  input  logic             hold_set,
  input  logic [CEN_W-1:0] century,
  input  logic             ld_en,
  input  logic [SEL_W-1:0] ld_sel,
  input  logic [FLD_W-1:0] ld_data,
  output logic [FLD_W-1:0] sec_o,
  output logic [FLD_W-1:0] min_o,
  output logic [FLD_W-1:0] hour_o,
  output logic [FLD_W-1:0] wday_o,
  output logic [FLD_W-1:0] mday_o,
  output logic [FLD_W-1:0] mon_o,
  output logic [FLD_W-1:0] year_o
);

  localparam int SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on the clock
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign arst_n = rsync_q[SYNC_STAGES-1];

  // state
  cal_t tm_q, tm_d;
  cal_t vis_q, vis_d;
  logic hold_q;
  logic tm_en, vis_en;

  // datapath
  cal_t base, step_out, enc_out, vis_dec;
  logic commit;
  logic ld_hit;
  fld_t ld_bin;

  caltime_step #(.CEN_W(CEN_W)) u_step (
    .cur     (base),
    .century (century),
    .nxt     (step_out)
  );

  caltime_codec u_codec (
    .bin_in     (tm_d),
    .ext_in     (vis_q),
    .fmt_binary (fmt_binary),
    .fmt_24h    (fmt_24h),
    .ext_out    (enc_out),
    .bin_out    (vis_dec)
  );

  always_comb begin
    commit = hold_q && !hold_set;
    base   = commit ? vis_dec : tm_q;
    ld_hit = ld_en && (int'(ld_sel) < NUM_FLD);
    ld_bin = decode_field(int'(ld_sel), ld_data, fmt_binary, fmt_24h);

    // internal time: frozen in set mode, load beats tick
    tm_d = base;
    if (ld_hit) begin
      for (int i = 0; i < NUM_FLD; i++) begin
        if (int'(ld_sel) == i) tm_d[i] = ld_bin;
      end
    end else if (tick_1s) begin
      tm_d = step_out;
    end

    // visible registers: raw staging in set mode, re-encoded otherwise
    vis_d = enc_out;
    if (hold_set) begin
      vis_d = vis_q;
      for (int i = 0; i < NUM_FLD; i++) begin
        if (ld_hit && int'(ld_sel) == i) vis_d[i] = ld_data;
      end
    end

    tm_en  = !hold_set;
    vis_en = !hold_set || ld_hit;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      tm_q   <= CAL_RESET;
      vis_q  <= CAL_RESET;
      hold_q <= 1'b0;
    end else begin
      hold_q <= hold_set;
      if (tm_en)  tm_q  <= tm_d;
      if (vis_en) vis_q <= vis_d;
    end
  end

  assign sec_o  = vis_q[I_SEC];
  assign min_o  = vis_q[I_MIN];
  assign hour_o = vis_q[I_HOUR];
  assign wday_o = vis_q[I_WDAY];
  assign mday_o = vis_q[I_MDAY];
  assign mon_o  = vis_q[I_MON];
  assign year_o = vis_q[I_YEAR];

endmodule

// File: rtl/caltime_core_chk.sv
module caltime_core_chk
  import caltime_pkg::*;
(
  input logic clk,
  input logic srst_n,
  input logic tick_1s,
  input logic hold_set,
  input logic hold_q,
  input logic ld_en,
  input logic fmt_binary,
  input logic fmt_24h,
  input cal_t tm,
  input cal_t vis,
  input fld_t sec_o,
  input fld_t hour_o
);

  logic plain_tick;
  assign plain_tick = tick_1s && !hold_set && !hold_q && !ld_en;

  // R2: a plain tick below 59 seconds adds one second
  a_r2_sec_advance: assert property (@(posedge clk) disable iff (!srst_n)
    (plain_tick && tm[I_SEC] < 8'd59) |=> tm[I_SEC] == $past(tm[I_SEC]) + 8'd1);

  // R3: day of week 7 at midnight becomes 1
  a_r3_wday_wrap: assert property (@(posedge clk) disable iff (!srst_n)
    (plain_tick && tm[I_SEC] == 8'd59 && tm[I_MIN] == 8'd59 &&
     tm[I_HOUR] == 8'd23 && tm[I_WDAY] == 8'd7) |=> tm[I_WDAY] == 8'd1);

  // R4: last second of December 31 moves to January and the next year
  a_r4_new_year: assert property (@(posedge clk) disable iff (!srst_n)
    (plain_tick && tm[I_SEC] == 8'd59 && tm[I_MIN] == 8'd59 &&
     tm[I_HOUR] == 8'd23 && tm[I_MDAY] == 8'd31 && tm[I_MON] == 8'd12 &&
     tm[I_YEAR] < 8'd99)
    |=> (tm[I_MON] == 8'd1 && tm[I_MDAY] == 8'd1 &&
         tm[I_YEAR] == $past(tm[I_YEAR]) + 8'd1));

  // R6: binary 24-hour mode shows seconds unchanged
  a_r6_binary_direct: assert property (@(posedge clk) disable iff (!srst_n)
    (!hold_set && fmt_binary && fmt_24h) |=> sec_o == tm[I_SEC]);

  // R7: PM flag follows the internal hour in 12-hour mode
  a_r7_pm_flag: assert property (@(posedge clk) disable iff (!srst_n)
    (!hold_set && !fmt_24h) |=> hour_o[7] == (tm[I_HOUR] >= 8'd12));

  // R10: set mode without a load keeps the outputs still
  a_r10_hold_freeze: assert property (@(posedge clk) disable iff (!srst_n)
    (hold_set && !ld_en) |=> $stable(vis));

endmodule

bind caltime_core caltime_core_chk u_chk (
  .clk        (clk),
  .srst_n     (arst_n),
  .tick_1s    (tick_1s),
  .hold_set   (hold_set),
  .hold_q     (hold_q),
  .ld_en      (ld_en),
  .fmt_binary (fmt_binary),
  .fmt_24h    (fmt_24h),
  .tm         (tm_q),
  .vis        (vis_q),
  .sec_o      (sec_o),
  .hour_o     (hour_o)
);

// File: tb/sim_caltime_core.sv
`timescale 1ns/1ps
module sim_caltime_core;

  logic       clk;
  logic       rst_n;
  logic       tick_1s;
  logic       fmt_binary;
  logic       fmt_24h;
  logic       hold_set;
  logic [6:0] century;
  logic       ld_en;
  logic [2:0] ld_sel;
  logic [7:0] ld_data;
  logic [7:0] sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o;

  int checks;
  int failures;

  caltime_core u0 (
    .clk(clk), .rst_n(rst_n), .tick_1s(tick_1s), .fmt_binary(fmt_binary),
    .fmt_24h(fmt_24h), .hold_set(hold_set), .century(century),
    .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .wday_o(wday_o),
    .mday_o(mday_o), .mon_o(mon_o), .year_o(year_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mode(input logic bin, input logic h24);
    @(negedge clk);
    fmt_binary = bin;
    fmt_24h    = h24;
    @(negedge clk);
  endtask

  task automatic ld(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_sel = sel; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic set_clock(input logic [7:0] s, m, h, wd, md, mo, yr);
    ld(3'd0, s); ld(3'd1, m); ld(3'd2, h); ld(3'd3, wd);
    ld(3'd4, md); ld(3'd5, mo); ld(3'd6, yr);
  endtask

  task automatic do_tick();
    @(negedge clk);
    tick_1s = 1'b1;
    @(negedge clk);
    tick_1s = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "sec",  sec_o,  8'h00);
    chk("R1", "min",  min_o,  8'h00);
    chk("R1", "hour", hour_o, 8'h00);
    chk("R1", "wday", wday_o, 8'h01);
    chk("R1", "mday", mday_o, 8'h01);
    chk("R1", "mon",  mon_o,  8'h01);
    chk("R1", "year", year_o, 8'h00);
  endtask

  task automatic t_rollover();
    set_clock(8'h59, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
    do_tick();
    chk("R2", "sec wrap",  sec_o,  8'h00);
    chk("R2", "min wrap",  min_o,  8'h00);
    chk("R2", "hour wrap", hour_o, 8'h00);
    chk("R3", "wday 7->1", wday_o, 8'h01);
    chk("R4", "mday",      mday_o, 8'h01);
    chk("R4", "mon 12->1", mon_o,  8'h01);
    chk("R4", "year 99->0", year_o, 8'h00);
    set_clock(8'h59, 8'h59, 8'h10, 8'h03, 8'h15, 8'h06, 8'h42);
    do_tick();
    chk("R2", "hour carry", hour_o, 8'h11);
    chk("R2", "min clear",  min_o,  8'h00);
    chk("R3", "wday same",  wday_o, 8'h03);
    set_clock(8'h59, 8'h59, 8'h23, 8'h03, 8'h15, 8'h06, 8'h42);
    do_tick();
    chk("R3", "wday 3->4", wday_o, 8'h04);
    chk("R4", "mday 15->16", mday_o, 8'h16);
    set_clock(8'h58, 8'h00, 8'h00, 8'h01, 8'h01, 8'h01, 8'h00);
    do_tick();
    chk("R2", "sec +1", sec_o, 8'h59);
  endtask

  task automatic feb_end(input logic [6:0] cen, input logic [7:0] yr,
                         input logic [7:0] exp_md, input logic [7:0] exp_mo);
    @(negedge clk);
    century = cen;
    set_clock(8'h59, 8'h59, 8'h23, 8'h01, 8'h28, 8'h02, yr);
    do_tick();
    chk("R5", "feb28 mday", mday_o, exp_md);
    chk("R5", "feb28 mon",  mon_o,  exp_mo);
  endtask

  task automatic t_leap();
    feb_end(7'd20, 8'h00, 8'h29, 8'h02);
    feb_end(7'd19, 8'h00, 8'h01, 8'h03);
    feb_end(7'd19, 8'h24, 8'h29, 8'h02);
    feb_end(7'd20, 8'h23, 8'h01, 8'h03);
    @(negedge clk);
    century = 7'd20;
    set_clock(8'h59, 8'h59, 8'h23, 8'h01, 8'h29, 8'h02, 8'h00);
    do_tick();
    chk("R5", "feb29 -> mar1", mon_o, 8'h03);
  endtask

  task automatic t_month_len();
    set_clock(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h04, 8'h10);
    do_tick();
    chk("R4", "apr30 mday", mday_o, 8'h01);
    chk("R4", "apr30 mon",  mon_o,  8'h05);
    set_clock(8'h59, 8'h59, 8'h23, 8'h01, 8'h30, 8'h01, 8'h10);
    do_tick();
    chk("R4", "jan30 mday", mday_o, 8'h31);
    do_tick();
    chk("R4", "jan31 not wrapped before midnight", mday_o, 8'h31);
    set_clock(8'h59, 8'h59, 8'h23, 8'h01, 8'h31, 8'h01, 8'h10);
    do_tick();
    chk("R4", "jan31 mon", mon_o, 8'h02);
    chk("R4", "year held", year_o, 8'h10);
  endtask

  task automatic t_binary();
    ld(3'd0, 8'h45);
    set_mode(1'b1, 1'b1);
    chk("R8", "sec to binary", sec_o, 8'h2D);
    chk("R6", "mon binary", mon_o, 8'h02);
    ld(3'd1, 8'h3B);
    chk("R6", "min load binary", min_o, 8'h3B);
    set_mode(1'b0, 1'b1);
    chk("R8", "min to bcd", min_o, 8'h59);
    chk("R6", "sec bcd", sec_o, 8'h45);
  endtask

  task automatic t_12h();
    ld(3'd2, 8'h00);
    set_mode(1'b0, 1'b0);
    chk("R7", "midnight as 12", hour_o, 8'h12);
    set_mode(1'b0, 1'b1);
    ld(3'd2, 8'h13);
    set_mode(1'b0, 1'b0);
    chk("R7", "13h as 1 PM", hour_o, 8'h81);
    ld(3'd2, 8'h92);
    chk("R7", "12 PM load", hour_o, 8'h92);
    set_mode(1'b0, 1'b1);
    chk("R7", "12 PM in 24h", hour_o, 8'h12);
    set_mode(1'b0, 1'b0);
    ld(3'd2, 8'h12);
    set_mode(1'b0, 1'b1);
    chk("R7", "12 AM in 24h", hour_o, 8'h00);
    set_mode(1'b0, 1'b0);
    ld(3'd0, 8'h59); ld(3'd1, 8'h59); ld(3'd2, 8'h11);
    do_tick();
    chk("R7", "11:59:59 AM -> 12 PM", hour_o, 8'h92);
    set_mode(1'b1, 1'b0);
    ld(3'd2, 8'h83);
    chk("R7", "binary 3 PM", hour_o, 8'h83);
    set_mode(1'b0, 1'b1);
    chk("R7", "3 PM in 24h bcd", hour_o, 8'h15);
  endtask

  task automatic t_hold();
    logic [7:0] s0, m0;
    set_clock(8'h30, 8'h20, 8'h10, 8'h02, 8'h05, 8'h07, 8'h33);
    @(negedge clk);
    hold_set = 1'b1;
    @(negedge clk);
    s0 = sec_o; m0 = min_o;
    set_mode(1'b1, 1'b1);
    chk("R10", "sec frozen on mode change", sec_o, s0);
    chk("R10", "min frozen on mode change", min_o, m0);
    do_tick();
    chk("R10", "tick ignored in hold", sec_o, 8'h30);
    ld(3'd0, 8'h1A);
    chk("R10", "raw staged sec", sec_o, 8'h1A);
    @(negedge clk);
    hold_set = 1'b0;
    @(negedge clk);
    chk("R10", "commit decoded binary sec", sec_o, 8'h1A);
    chk("R10", "commit min 0x20 read as 32", min_o, 8'h20);
    do_tick();
    chk("R10", "tick after commit", sec_o, 8'h1B);
    set_mode(1'b0, 1'b1);
    chk("R10", "min re-encoded bcd 32", min_o, 8'h32);
    @(negedge clk);
    hold_set = 1'b1;
    ld(3'd0, 8'h45);
    @(negedge clk);
    hold_set = 1'b0;
    do_tick();
    chk("R10", "bcd commit then tick", sec_o, 8'h46);
  endtask

  task automatic t_ignored();
    logic [55:0] snap;
    set_clock(8'h10, 8'h20, 8'h05, 8'h04, 8'h12, 8'h03, 8'h07);
    snap = {sec_o, min_o, hour_o, wday_o, mday_o, mon_o, year_o};
    ld(3'd7, 8'h55);
    chk("R9", "sel7 sec",  sec_o,  snap[55:48]);
    chk("R9", "sel7 min",  min_o,  snap[47:40]);
    chk("R9", "sel7 hour", hour_o, snap[39:32]);
    chk("R9", "sel7 wday", wday_o, snap[31:24]);
    chk("R9", "sel7 mday", mday_o, snap[23:16]);
    chk("R9", "sel7 mon",  mon_o,  snap[15:8]);
    chk("R9", "sel7 year", year_o, snap[7:0]);
    @(negedge clk);
    tick_1s = 1'b1; ld_en = 1'b1; ld_sel = 3'd1; ld_data = 8'h33;
    @(negedge clk);
    tick_1s = 1'b0; ld_en = 1'b0;
    chk("R9", "load beats tick: sec", sec_o, 8'h10);
    chk("R9", "load beats tick: min", min_o, 8'h33);
  endtask

  task automatic t_year_norm();
    set_mode(1'b1, 1'b1);
    ld(3'd6, 8'h96);
    chk("R11", "binary 150 -> 50", year_o, 8'h32);
    set_mode(1'b0, 1'b1);
    ld(3'd6, 8'hA5);
    chk("R11", "bcd A5 -> 05", year_o, 8'h05);
    ld(3'd6, 8'hF9);
    chk("R11", "bcd F9 -> 59", year_o, 8'h59);
  endtask

  initial begin
    #400000;
    checks++;
    failures++;
    $display("FAIL watchdog: run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0; failures = 0;
    rst_n = 1'b0; tick_1s = 1'b0; fmt_binary = 1'b0; fmt_24h = 1'b1;
    hold_set = 1'b0; century = 7'd20; ld_en = 1'b0; ld_sel = 3'd0; ld_data = 8'h00;
    cycles(4);
    rst_n = 1'b1;
    cycles(4);
    t_reset();
    t_rollover();
    t_leap();
    t_month_len();
    t_binary();
    t_12h();
    t_hold();
    t_ignored();
    t_year_norm();
    cycles(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule